// File: doc/BRIEF.md
# Replicated-Block Comparison Self-Test Harness

This block is a self-test wrapper around a set of identical combinational blocks under test. A plain binary counter serves as the pattern source. After a start pulse it steps through every input combination, one per clock, at full clock rate. All replicas see the same pattern. Their outputs are registered, and a row of comparators checks them against one another. The check is agreement between copies, with no compacted signature. Any copy that breaks from its neighbours sets a flag.

The comparators split the replicas into overlapping groups of at most four. Neighbouring groups share their boundary block, so every replica is compared with at least one other. Each comparator feeds its own error bit back into its next state, so the first disagreement locks its flag until the next start. A fault-injection port lets a testbench hold any output bit of any replica at a fixed value. A sweep-width parameter shortens the run for simulation, and its default covers the full input width.

Top module: `lbist_harness`

## Requirements
- R1: A start pulse clears the pattern counter and every fail flag. From the following cycle, busy is 1, done is 0 and all fail flags are 0. A start is honoured in any state.
- R2: A run applies patterns 0 to 2^SWEEP_W-1 in ascending order, one per cycle. Done rises, and busy falls, exactly 2^SWEEP_W+1 clock edges after the edge that sampled start. Busy stays 1 and done stays 0 on every edge before that.
- R3: There are ceil((NUM_BUT-1)/3) comparators. Comparator g watches blocks 3g through min(3g+3, NUM_BUT-1).
- R4: A comparator flags a mismatch when any output bit position differs among the blocks it watches for any pattern of the run. A comparator watching two blocks uses a bitwise difference, and one watching three or four blocks tests each bit for unanimity.
- R5: A set fail flag stays set for the rest of the run and after done, until the next start.
- R6: With no fault injected, every fail flag is 0 when done rises.
- R7: The pattern applied in the first cycle of the run, pattern 0, is compared. A fault present only while pattern 0 is applied is detected.
- R8: The last pattern, all ones in the swept bits, is compared in the extra cycle after the wrap. A fault present only while that pattern is applied is detected.
- R9: Each block under test maps its IN_W-bit input to OUT_W output bits. Output bit k is the XOR of all input bits i with i mod OUT_W = k, further XORed with (in[k] AND in[(k+1) mod IN_W]). Input bits at or above SWEEP_W are held at 0.
- R10: While faultEn is 1, output bit faultBit of block faultBut is forced to faultVal. The flags that end up set are exactly those of the comparators that watch that block.
- R11: After done, the fail flags and done hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears state and begins a sweep |
| faultEn | input | 1 | Enables the stuck-at injection |
| faultBut | input | idxW(NUM_BUT) | Block whose output is forced |
| faultBit | input | idxW(OUT_W) | Output bit that is forced |
| faultVal | input | 1 | Value the forced bit takes |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, flags final |
| failFlags | output | oraCount(NUM_BUT) | Sticky mismatch flag per comparator |

## Verification
The bench builds the block with eight replicas and an 8-bit sweep, keeping the 18-bit input and 4-bit output. With eight replicas there are three comparators: two watch four blocks and one watches two. This brings both comparison styles within reach, along with the shared boundary blocks 3 and 6, which must set two flags at once. The short sweep keeps each run near 260 cycles. That leaves room for many randomly placed stuck-at faults, plus directed faults timed to hit only the first or only the last pattern and so exercise the pipeline edges of the comparison window.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  // Index width that never collapses to zero bits.
  function automatic int idxW(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Comparator groups: stride of three, so neighbours share one block.
  function automatic int oraCount(input int nBut);
    return (nBut + 1) / 3;
  endfunction

  function automatic int grpFirst(input int g);
    return 3 * g;
  endfunction

  function automatic int grpSize(input int g, input int nBut);
    int last;
    last = 3 * g + 3;
    if (last > nBut - 1) last = nBut - 1;
    return last - 3 * g + 1;
  endfunction

  typedef struct packed {
    logic clear;  // reset counter, pipeline and flags
    logic step;   // apply next pattern and capture outputs
  } lbistStrobe_t;

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         lastPat,
  output lbistStrobe_t strobe,
  output logic         busy,
  output logic         done
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } ctrlState_t;

  ctrlState_t state;

  always_comb begin
    strobe.clear = start;
    strobe.step  = (state == ST_RUN) && !start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      state <= ST_RUN;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (lastPat) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbist_ora.sv
module lbist_ora #(
  parameter int SIZE  = 4,
  parameter int OUT_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      clear,
  input  logic                      cmpEn,
  input  logic [SIZE-1:0][OUT_W-1:0] outs,
  output logic                      fail
);

  logic [OUT_W-1:0] diff;

  generate
    if (SIZE == 2) begin : gPair
      assign diff = outs[0] ^ outs[1];
    end else begin : gVote
      always_comb begin
        for (int k = 0; k < OUT_W; k++) begin
          logic anyOne;
          logic allOne;
          anyOne = 1'b0;
          allOne = 1'b1;
          for (int j = 0; j < SIZE; j++) begin
            anyOne = anyOne | outs[j][k];
            allOne = allOne & outs[j][k];
          end
          diff[k] = anyOne & ~allOne;
        end
      end
    end
  endgenerate

  // The flag is its own input: once set it can only be cleared by start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       fail <= 1'b0;
    else if (clear)  fail <= 1'b0;
    else if (cmpEn)  fail <= fail | (|diff);
  end

endmodule

// File: rtl/lbist_datapath.sv
module lbist_datapath
  import lbist_pkg::*;
#(
  parameter int NUM_BUT = 4,
  parameter int IN_W    = 18,
  parameter int OUT_W   = 4,
  parameter int SWEEP_W = 18
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  lbistStrobe_t                strobe,
  input  logic                        faultEn,
  input  logic [idxW(NUM_BUT)-1:0]    faultBut,
  input  logic [idxW(OUT_W)-1:0]      faultBit,
  input  logic                        faultVal,
  output logic                        lastPat,
  output logic [oraCount(NUM_BUT)-1:0] failFlags
);

  localparam int NUM_ORA = oraCount(NUM_BUT);
  localparam int BUT_IW  = idxW(NUM_BUT);
  localparam int BIT_IW  = idxW(OUT_W);

  logic [SWEEP_W-1:0] cnt;
  logic [IN_W-1:0]    pattern;
  logic               capValid;
  logic [OUT_W-1:0]   rawOut [NUM_BUT];
  logic [OUT_W-1:0]   capOut [NUM_BUT];

  assign pattern = IN_W'(cnt);
  assign lastPat = &cnt;

  function automatic logic [OUT_W-1:0] butFunc(input logic [IN_W-1:0] din);
    logic [OUT_W-1:0] res;
    res = '0;
    for (int i = 0; i < IN_W; i++) res[i % OUT_W] = res[i % OUT_W] ^ din[i];
    for (int k = 0; k < OUT_W; k++) res[k] = res[k] ^ (din[k % IN_W] & din[(k + 1) % IN_W]);
    return res;
  endfunction

  generate
    for (genvar b = 0; b < NUM_BUT; b++) begin : gBut
      always_comb begin
        rawOut[b] = butFunc(pattern);
        if (faultEn && (faultBut == BUT_IW'(b))) begin
          for (int k = 0; k < OUT_W; k++)
            if (faultBit == BIT_IW'(k)) rawOut[b][k] = faultVal;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      capValid <= 1'b0;
      for (int b = 0; b < NUM_BUT; b++) capOut[b] <= '0;
    end else if (strobe.clear) begin
      cnt      <= '0;
      capValid <= 1'b0;
    end else begin
      capValid <= strobe.step;
      if (strobe.step) begin
        cnt <= cnt + 1'b1;
        for (int b = 0; b < NUM_BUT; b++) capOut[b] <= rawOut[b];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_ORA; g++) begin : gOra
      localparam int FIRST = grpFirst(g);
      localparam int SIZE  = grpSize(g, NUM_BUT);
      logic [SIZE-1:0][OUT_W-1:0] grpOuts;
      for (genvar j = 0; j < SIZE; j++) begin : gTap
        assign grpOuts[j] = capOut[FIRST + j];
      end
      lbist_ora #(
        .SIZE (SIZE),
        .OUT_W(OUT_W)
      ) uOra (
        .clk  (clk),
        .rstN (rstN),
        .clear(strobe.clear),
        .cmpEn(capValid),
        .outs (grpOuts),
        .fail (failFlags[g])
      );
    end
  endgenerate

endmodule

// File: rtl/lbist_harness.sv
module lbist_harness
  import lbist_pkg::*;
#(
  parameter int NUM_BUT = 4,
  parameter int IN_W    = 18,
  parameter int OUT_W   = 4,
  parameter int SWEEP_W = 18
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         faultEn,
  input  logic [idxW(NUM_BUT)-1:0]     faultBut,
  input  logic [idxW(OUT_W)-1:0]       faultBit,
  input  logic                         faultVal,
  output logic                         busy,
  output logic                         done,
  output logic [oraCount(NUM_BUT)-1:0] failFlags
);

  lbistStrobe_t strobe;
  logic         lastPat;

  lbist_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .lastPat(lastPat),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  lbist_datapath #(
    .NUM_BUT(NUM_BUT),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .SWEEP_W(SWEEP_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .faultEn  (faultEn),
    .faultBut (faultBut),
    .faultBit (faultBit),
    .faultVal (faultVal),
    .lastPat  (lastPat),
    .failFlags(failFlags)
  );

endmodule

// File: rtl/lbist_harness_chk.sv
module lbist_harness_chk #(
  parameter int NUM_ORA = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [NUM_ORA-1:0] failFlags
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done && (failFlags == '0))); // R1

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R2

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!start && busy) |=> ((failFlags & $past(failFlags)) == $past(failFlags))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(failFlags) && $stable(done))); // R11

endmodule

bind lbist_harness lbist_harness_chk #(
  .NUM_ORA(lbist_pkg::oraCount(NUM_BUT))
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .failFlags(failFlags)
);

// File: tb/lbist_harness_test.sv
`timescale 1ns/1ps
module lbist_harness_test;

  localparam int NB  = 8;
  localparam int IW  = 18;
  localparam int OW  = 4;
  localparam int SW  = 8;
  localparam int NO  = (NB + 1) / 3;
  localparam int NPAT = 1 << SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          faultEn = 1'b0;
  logic [2:0]    faultBut = '0;
  logic [1:0]    faultBit = '0;
  logic          faultVal = 1'b0;
  logic          busy, done;
  logic [NO-1:0] failFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lbist_harness #(
    .NUM_BUT(NB), .IN_W(IW), .OUT_W(OW), .SWEEP_W(SW)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .faultEn(faultEn),
    .faultBut(faultBut), .faultBit(faultBit), .faultVal(faultVal),
    .busy(busy), .done(done), .failFlags(failFlags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R9 reference function
  function automatic logic [OW-1:0] refBut(input logic [IW-1:0] din);
    logic [OW-1:0] r;
    r = '0;
    for (int i = 0; i < IW; i++) r[i % OW] ^= din[i];
    for (int k = 0; k < OW; k++) r[k] ^= din[k] & din[(k + 1) % IW];
    return r;
  endfunction

  // R3 grouping: flags expected when block fb is faulty
  function automatic logic [NO-1:0] expFlags(input int fb);
    logic [NO-1:0] m;
    m = '0;
    for (int g = 0; g < NO; g++) begin
      int last;
      last = (3 * g + 3 > NB - 1) ? NB - 1 : 3 * g + 3;
      if (fb >= 3 * g && fb <= last) m[g] = 1'b1;
    end
    return m;
  endfunction

  // mode: 0 no fault, 1 whole run, 2 first pattern only, 3 last pattern only
  task automatic doRun(input int fb, input int fk, input bit fv, input int mode,
                       input logic [NO-1:0] exp, input string req);
    int seqErr;
    logic [NO-1:0] held;
    seqErr = 0;
    @(negedge clk);
    start = 1'b1;
    faultBut = 3'(fb); faultBit = 2'(fk); faultVal = fv;
    faultEn = (mode == 1);
    @(negedge clk);
    check(busy && !done && failFlags == '0, "R1", "state after start",
          {busy, done, failFlags}, {2'b10, NO'(0)});
    start = 1'b0;
    if (mode == 2) faultEn = 1'b1;
    for (int c = 1; c <= NPAT + 1; c++) begin
      @(negedge clk);
      if (mode == 2 && c == 1) faultEn = 1'b0;
      if (mode == 3 && c == NPAT - 1) faultEn = 1'b1;
      if (mode == 3 && c == NPAT) faultEn = 1'b0;
      if (c <= NPAT && !(busy && !done)) seqErr++;
    end
    check(seqErr == 0, "R2", "busy/done before end", seqErr, 0);
    check(done && !busy, "R2", "done timing", {busy, done}, 2'b01);
    check(failFlags == exp, req, "fail flags", failFlags, exp);
    faultEn = 1'b0;
    held = failFlags;
    repeat (5) @(negedge clk);
    check(done && failFlags == held, "R11", "hold after done",
          {done, failFlags}, {1'b1, held});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && failFlags == '0, "R1", "reset state",
          {busy, done, failFlags}, 0);
    rstN = 1'b1;

    doRun(0, 0, 0, 0, '0, "R6");                              // R6 clean run
    doRun(3, 1, 1, 1, expFlags(3), "R10");                    // R10 shared block
    doRun(7, 2, 0, 1, expFlags(7), "R4");                     // R4 pair comparator
    doRun(0, 0, 0, 0, '0, "R1");                              // R1 flags cleared by start
    doRun(5, 0, ~refBut('0) >> 0, 2, expFlags(5), "R7");      // R7 first pattern
    doRun(1, 3, ~refBut(IW'(NPAT - 1))[3], 3, expFlags(1), "R8"); // R8 last pattern
    doRun(6, 1, ~refBut(IW'(NPAT - 1))[1], 3, expFlags(6), "R5"); // R5 brief fault stays flagged

    void'($urandom(1234));
    for (int n = 0; n < 8; n++) begin
      int fb, fk;
      bit fv;
      fb = $urandom_range(NB - 1);
      fk = $urandom_range(OW - 1);
      fv = 1'($urandom);
      doRun(fb, fk, fv, 1, expFlags(fb), "R4");
    end
    doRun(2, 0, 0, 0, '0, "R6");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule